// File: doc/BRIEF.md
# DVMA Page Translation Unit

This block turns a DMA transfer, given as a device virtual address, a byte length and a direction, into one or more physical-address requests. It looks each page up in a single-level table kept in system memory. The transfer is cut into segments. Each segment ends at the next 4 KB page boundary or at the end of the transfer, whichever comes first. For every segment the unit reads one 32-bit table entry through a memory read port. It then checks that entry, and either passes on a physical request or stops the whole transfer with a fault.

A window-size selector sets how many upper address bits are stripped from the virtual address before indexing. A table base value places the table in memory. Both are sampled when a request is accepted.

The request input, the memory fetch port and the segment output are valid/ready streams. A source holds `req_valid` and its fields until `req_ready` is seen high. The unit holds `mrd_valid`/`mrd_addr` and `out_valid` with its fields steady until the matching ready is high on a clock edge. Read data is taken on any cycle `mrd_rvalid` is high while a fetch is outstanding. `xfer_done`, `xfer_err` and the two fault registers are plain signals.

Top module: `dvma_xlate`

## Requirements
- R1: `req_ready` is high only while no transfer is in progress, and is low from the cycle after a non-empty request is accepted until the transfer ends. `range_sel`, `tbl_base` and the request fields are captured at acceptance, and later changes to them do not affect that transfer.
- R2: The entry address for a page is `tbl_base * 16 + 4 * floor((va mod W) / 4096)`. Here W is 16 MB shifted left by `range_sel` (0 = 16 MB up to 7 = 2 GB).
- R3: A transfer of length L at address A is emitted as consecutive segments. Each segment runs from the current address to the next multiple of 4096 or to A+L, whichever is nearer. A length of zero produces no fetch and no segment.
- R4: One table fetch is outstanding at a time, and exactly one fetch is made per segment examined. `mrd_valid` and `mrd_addr` hold until `mrd_ready` is sampled high.
- R5: For an accepted entry, `out_paddr = entry[26:8] * 4096 + (va mod 4096)`. Entry bits 31:27, 7:3 and 0 have no effect. Entry bits are used exactly as returned.
- R6: `out_valid` and its fields hold until `out_ready` is sampled high. `out_write` equals the request direction.
- R7: An entry with bit 1 clear, or a write request meeting an entry with bit 2 clear, ends the transfer with no segment for that page or any later page. `xfer_err` pulses for one cycle, one cycle after the faulting entry is sampled.
- R8: On a fault, `fault_status` becomes 0xC0820000 for a write and 0xC0860000 for a read. `fault_addr` becomes the faulting page's virtual address with bits 11:0 cleared. Both keep their values until the next fault.
- R9: `xfer_done` pulses for one cycle, one cycle after the last segment's output handshake, or one cycle after a zero-length request is accepted. Each transfer ends with exactly one of `xfer_done` and `xfer_err`.
- R10: After reset, `req_ready` is 1, `mrd_valid`, `out_valid`, `xfer_done` and `xfer_err` are 0, `fault_status` is 0x00800000 and `fault_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| range_sel | input | 3 | Translation window size select |
| tbl_base | input | 32 | Table base value (byte address divided by 16) |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Transfer start virtual address |
| req_len | input | 16 | Transfer length in bytes |
| req_write | input | 1 | 1 = write transfer, 0 = read |
| mrd_valid | output | 1 | Table fetch request valid |
| mrd_ready | input | 1 | Memory accepts the fetch |
| mrd_addr | output | 36 | Byte address of the table entry |
| mrd_rvalid | input | 1 | Entry data valid |
| mrd_rdata | input | 32 | Table entry |
| out_valid | output | 1 | Translated segment valid |
| out_ready | input | 1 | Consumer accepts the segment |
| out_paddr | output | 36 | Segment physical address |
| out_len | output | 16 | Segment length in bytes |
| out_write | output | 1 | Segment direction |
| xfer_done | output | 1 | Transfer completed pulse |
| xfer_err | output | 1 | Transfer aborted pulse |
| fault_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Faulting page virtual address |

## Verification
A fetch appears on the cycle after acceptance or after the previous segment's handshake. A segment appears the cycle after its entry is sampled. `xfer_err` follows one cycle after the faulting entry, and `xfer_done` follows one cycle after the last handshake, or one cycle after acceptance for an empty transfer. The bench drives every input once per cycle on the falling edge. It decides each ready value before looking at the matching valid, so it knows on which rising edge each handshake and entry sample happens. It then demands each pulse on exactly the following falling edge and compares the fault registers once the transfer has ended.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_EMIT
  } xl_state_e;

  // fault status flag values
  localparam logic [31:0] FLT_ANY    = 32'h8000_0000;
  localparam logic [31:0] FLT_LATE   = 32'h4000_0000;
  localparam logic [31:0] FLT_FIXED  = 32'h0080_0000;
  localparam logic [31:0] FLT_READ   = 32'h0004_0000;
  localparam logic [31:0] FLT_AVALID = 32'h0002_0000;

  // table entry fields
  localparam int ENT_VALID = 1;
  localparam int ENT_WRITE = 2;
  localparam int ENT_PPN_LO = 8;
  localparam int ENT_PPN_HI = 26;

endpackage

// File: rtl/dvma_seg_calc.sv
module dvma_seg_calc #(
  parameter int LEN_W   = 16,
  parameter int PG_BITS = 12
) (
  input  logic [PG_BITS-1:0] page_off,
  input  logic [LEN_W-1:0]   remain,
  output logic [LEN_W-1:0]   seg_len,
  output logic               seg_last
);
  localparam int RW = PG_BITS + 1;
  localparam int CW = (LEN_W > RW) ? LEN_W : RW;

  logic [RW-1:0] room;
  logic [CW-1:0] rem_x, room_x;

  // bytes left before the next page boundary
  assign room   = RW'(1 << PG_BITS) - {1'b0, page_off};
  assign rem_x  = CW'(remain);
  assign room_x = CW'(room);

  assign seg_last = (rem_x <= room_x);
  assign seg_len  = seg_last ? remain : LEN_W'(room_x);

endmodule

// File: rtl/dvma_pte_eval.sv
module dvma_pte_eval
  import dvma_pkg::*;
#(
  parameter int PA_W    = 36,
  parameter int PG_BITS = 12
) (
  input  logic [31:0]        entry,
  input  logic [PG_BITS-1:0] page_off,
  input  logic               is_write,
  output logic               ok,
  output logic [PA_W-1:0]    paddr
);
  // only valid and write bits gate; cache and write-as-zero bits ignored
  assign ok    = entry[ENT_VALID] && (!is_write || entry[ENT_WRITE]);
  assign paddr = PA_W'({entry[ENT_PPN_HI:ENT_PPN_LO], page_off});

endmodule

// File: rtl/dvma_fault_rec.sv
module dvma_fault_rec
  import dvma_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PG_BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            was_read,
  input  logic [VA_W-1:0] fail_va,
  output logic [31:0]     status,
  output logic [VA_W-1:0] fail_page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= FLT_FIXED;
      fail_page <= '0;
    end else if (load) begin
      status    <= FLT_ANY | FLT_LATE | FLT_FIXED | FLT_AVALID |
                   (was_read ? FLT_READ : 32'h0);
      fail_page <= {fail_va[VA_W-1:PG_BITS], {PG_BITS{1'b0}}};
    end
  end

  p_fault_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> status[31] && status[30] && status[23] && status[17] &&
             (status[18] == $past(was_read)));

  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(status) && $stable(fail_page));

endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 36,
  parameter int LEN_W   = 16,
  parameter int PG_BITS = 12,
  parameter int SEL_W   = 3,
  parameter int WIN_MIN = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] range_sel,
  input  logic [31:0]      tbl_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  output logic             mrd_valid,
  input  logic             mrd_ready,
  output logic [PA_W-1:0]  mrd_addr,
  input  logic             mrd_rvalid,
  input  logic [31:0]      mrd_rdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PA_W-1:0]  out_paddr,
  output logic [LEN_W-1:0] out_len,
  output logic             out_write,
  output logic             xfer_done,
  output logic             xfer_err,
  output logic [31:0]      fault_status,
  output logic [VA_W-1:0]  fault_addr
);
  localparam int WIN_N  = 1 << SEL_W;
  localparam int PG_SZ  = 1 << PG_BITS;

  xl_state_e        st;
  logic [VA_W-1:0]  cur_va;
  logic [LEN_W-1:0] rem_q;
  logic             wr_q;
  logic [SEL_W-1:0] sel_q;
  logic [31:0]      base_q;
  logic [PA_W-1:0]  pa_q;
  logic [LEN_W-1:0] seg_q;
  logic             last_q;
  logic             done_q, err_q;

  // window masks, one per selector value
  logic [VA_W-1:0] mask_tab [WIN_N];
  for (genvar g = 0; g < WIN_N; g++) begin : g_win
    localparam int SH = WIN_MIN + g;
    if (SH >= VA_W) begin : g_full
      assign mask_tab[g] = '1;
    end else begin : g_part
      assign mask_tab[g] = VA_W'((64'd1 << SH) - 64'd1);
    end
  end

  logic [VA_W-1:0] win_off;
  assign win_off  = cur_va & mask_tab[sel_q];
  assign mrd_addr = (PA_W'(base_q) << 4) + (PA_W'(win_off >> PG_BITS) << 2);

  logic [LEN_W-1:0] seg_len;
  logic             seg_last;
  dvma_seg_calc #(.LEN_W(LEN_W), .PG_BITS(PG_BITS)) i_seg (
    .page_off (cur_va[PG_BITS-1:0]),
    .remain   (rem_q),
    .seg_len  (seg_len),
    .seg_last (seg_last)
  );

  logic            ent_ok;
  logic [PA_W-1:0] ent_pa;
  dvma_pte_eval #(.PA_W(PA_W), .PG_BITS(PG_BITS)) i_eval (
    .entry    (mrd_rdata),
    .page_off (cur_va[PG_BITS-1:0]),
    .is_write (wr_q),
    .ok       (ent_ok),
    .paddr    (ent_pa)
  );

  logic flt_load;
  assign flt_load = (st == S_WAIT) && mrd_rvalid && !ent_ok;

  dvma_fault_rec #(.VA_W(VA_W), .PG_BITS(PG_BITS)) i_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (flt_load),
    .was_read  (!wr_q),
    .fail_va   (cur_va),
    .status    (fault_status),
    .fail_page (fault_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur_va <= '0;
      rem_q  <= '0;
      wr_q   <= 1'b0;
      sel_q  <= '0;
      base_q <= '0;
      pa_q   <= '0;
      seg_q  <= '0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          cur_va <= req_vaddr;
          rem_q  <= req_len;
          wr_q   <= req_write;
          sel_q  <= range_sel;
          base_q <= tbl_base;
          if (req_len == '0) done_q <= 1'b1;
          else               st     <= S_FETCH;
        end
        S_FETCH: if (mrd_ready) st <= S_WAIT;
        S_WAIT: if (mrd_rvalid) begin
          if (ent_ok) begin
            pa_q   <= ent_pa;
            seg_q  <= seg_len;
            last_q <= seg_last;
            st     <= S_EMIT;
          end else begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end
        end
        S_EMIT: if (out_ready) begin
          cur_va <= cur_va + VA_W'(seg_q);
          rem_q  <= rem_q - seg_q;
          if (last_q) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign mrd_valid = (st == S_FETCH);
  assign out_valid = (st == S_EMIT);
  assign out_paddr = pa_q;
  assign out_len   = seg_q;
  assign out_write = wr_q;
  assign xfer_done = done_q;
  assign xfer_err  = err_q;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mrd_valid && !out_valid);

  p_fetch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_paddr) &&
                                $stable(out_len) && $stable(out_write));

  p_seg_in_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0) &&
      (int'(out_paddr[PG_BITS-1:0]) + int'(out_len) <= PG_SZ));

  p_err_after_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> $past(mrd_rvalid));

  p_one_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && xfer_err));

endmodule

// File: tb/test_dvma_xlate.sv
module test_dvma_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  range_sel = '0;
  logic [31:0] tbl_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [15:0] req_len = '0;
  logic        req_write = 1'b0;
  logic        mrd_valid;
  logic        mrd_ready = 1'b0;
  logic [35:0] mrd_addr;
  logic        mrd_rvalid = 1'b0;
  logic [31:0] mrd_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [35:0] out_paddr;
  logic [15:0] out_len;
  logic        out_write;
  logic        xfer_done, xfer_err;
  logic [31:0] fault_status, fault_addr;

  always #5 clk = ~clk;

  dvma_xlate i_dvma_xlate (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_len(req_len), .req_write(req_write),
    .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
    .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_paddr(out_paddr),
    .out_len(out_len), .out_write(out_write),
    .xfer_done(xfer_done), .xfer_err(xfer_err),
    .fault_status(fault_status), .fault_addr(fault_addr)
  );

  int total = 0, bad = 0, cyc = 0;
  int busy = 0;
  logic [35:0] cap_addr = '0;
  logic [63:0] exp_pa [64];
  int exp_len [64];
  int exp_n, exp_fetch, seg_idx, fetch_cnt;
  bit exp_fault, cur_wr, pending_done, fin_done, fin_err;
  logic [31:0] m_status = 32'h0080_0000, m_faddr = '0;

  task automatic chk(input bit c, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // table content as a function of entry byte address, with junk in unused bits
  function automatic logic [31:0] ent_at(input logic [63:0] a);
    logic [63:0] h, ppn;
    logic [31:0] e;
    h   = a >> 2;
    ppn = (h * 64'd40503 + 64'd12345) & 64'h7FFFF;
    e   = {h[4:0], ppn[18:0], h[0], h[5:2], ((h % 6) != 4), ((h % 11) != 7), h[1]};
    return e;
  endfunction

  task automatic tick();
    bit nr;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (xfer_err) begin
      fin_err = 1;
      chk(mrd_rvalid === 1'b1, "R7", "err one cycle after entry", 64'(mrd_rvalid), 1);
    end
    if (pending_done) begin
      chk(xfer_done === 1'b1, "R9", "done due", 64'(xfer_done), 1);
      if (xfer_done) fin_done = 1;
    end else if (xfer_done) begin
      chk(0, "R9", "unexpected done", 1, 0);
      fin_done = 1;
    end
    pending_done = 0;
    // memory model
    mrd_rvalid = 1'b0;
    if (busy > 0) begin
      busy--;
      if (busy == 0) begin
        mrd_rvalid = 1'b1;
        mrd_rdata  = ent_at(64'(cap_addr));
      end
    end
    nr = (busy == 0) && (cyc % 3 != 0);
    mrd_ready = nr;
    if (mrd_valid && nr) begin
      cap_addr = mrd_addr;
      busy = 1 + (cyc % 3);
      fetch_cnt++;
    end
    // output consumer
    nr = (cyc % 4 != 1);
    out_ready = nr;
    if (out_valid && nr) begin
      if (seg_idx < exp_n) begin
        chk(64'(out_paddr) == exp_pa[seg_idx], "R5", "segment paddr",
            64'(out_paddr), exp_pa[seg_idx]);
        chk(int'(out_len) == exp_len[seg_idx], "R3", "segment length",
            64'(out_len), 64'(exp_len[seg_idx]));
        chk(out_write == cur_wr, "R6", "segment direction", 64'(out_write), 64'(cur_wr));
      end else begin
        chk(0, "R7", "extra segment", 64'(seg_idx), 64'(exp_n));
      end
      seg_idx++;
      if (seg_idx == exp_n && !exp_fault) pending_done = 1;
    end
  endtask

  task automatic run_req(input logic [31:0] va, input int len, input bit wr,
                         input int sel, input logic [31:0] base);
    logic [63:0] win, cur, off, ea, fpage;
    logic [31:0] e;
    int rem, room, sg;
    win = 64'h100_0000 << sel;
    cur = 64'(va); rem = len;
    exp_n = 0; exp_fetch = 0; exp_fault = 0; fpage = 0;
    for (int it = 0; it < 64 && rem > 0 && !exp_fault; it++) begin
      room = 4096 - int'(cur % 4096);
      sg   = (rem < room) ? rem : room;
      off  = cur % win;
      ea   = 64'(base) * 16 + (off / 4096) * 4;
      e    = ent_at(ea);
      exp_fetch++;
      if (!e[1] || (wr && !e[2])) begin
        exp_fault = 1;
        fpage = cur & ~64'hFFF;
      end else begin
        exp_pa[exp_n]  = 64'(e[26:8]) * 4096 + (cur % 4096);
        exp_len[exp_n] = sg;
        exp_n++;
        cur = cur + 64'(sg);
        rem = rem - sg;
      end
    end
    cur_wr = wr; seg_idx = 0; fetch_cnt = 0; fin_done = 0; fin_err = 0;
    pending_done = (len == 0);
    range_sel = 3'(sel); tbl_base = base;
    req_vaddr = va; req_len = 16'(len); req_write = wr; req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    range_sel = ~3'(sel); tbl_base = ~base; req_vaddr = ~va; req_write = ~wr;
    if (len != 0)
      chk(req_ready === 1'b0, "R1", "busy after accept", 64'(req_ready), 0);
    for (int t = 0; t < 4000 && !(fin_done || fin_err); t++) tick();
    chk(fin_done == !exp_fault, "R9", "done ending", 64'(fin_done), 64'(!exp_fault));
    chk(fin_err == exp_fault, "R7", "err ending", 64'(fin_err), 64'(exp_fault));
    chk(seg_idx == exp_n, "R3", "segment count", 64'(seg_idx), 64'(exp_n));
    chk(fetch_cnt == exp_fetch, "R4", "fetch count", 64'(fetch_cnt), 64'(exp_fetch));
    if (exp_fault) begin
      m_status = wr ? 32'hC082_0000 : 32'hC086_0000;
      m_faddr  = 32'(fpage);
    end
    chk(fault_status == m_status, "R8", "fault status", 64'(fault_status), 64'(m_status));
    chk(fault_addr == m_faddr, "R8", "fault address", 64'(fault_addr), 64'(m_faddr));
    chk(req_ready === 1'b1, "R1", "ready after end", 64'(req_ready), 1);
  endtask

  function automatic int len_of(input int k);
    case (k % 10)
      0: return 1;
      1: return 4096;
      2: return 100;
      3: return 5000;
      4: return 12000;
      5: return 0;
      6: return 4095;
      7: return 8192;
      8: return 3;
      default: return 9000;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready === 1'b1, "R10", "req_ready", 64'(req_ready), 1);
    chk(mrd_valid === 1'b0, "R10", "mrd_valid", 64'(mrd_valid), 0);
    chk(out_valid === 1'b0, "R10", "out_valid", 64'(out_valid), 0);
    chk(xfer_done === 1'b0 && xfer_err === 1'b0, "R10", "pulses", 64'({xfer_done, xfer_err}), 0);
    chk(fault_status == 32'h0080_0000, "R10", "fault_status", 64'(fault_status), 64'h80_0000);
    chk(fault_addr == 32'h0, "R10", "fault_addr", 64'(fault_addr), 0);
    // sweep over window sizes (R2), offsets and lengths
    for (int sel = 0; sel < 8; sel++) begin
      for (int k = 0; k < 10; k++) begin
        logic [31:0] va;
        va = 32'(64'hC3A5_0000 + 64'(k) * 64'h0013_5791 + 64'(sel) * 64'h0101_0101);
        if (k % 3 == 0) va[11:0] = 12'h000;
        run_req(va, len_of(k + sel), ((k ^ sel) & 1) == 1, sel,
                32'h0008_0000 + 32'(sel) * 32'h1230);
      end
    end
    // one-byte-before-boundary crossings, read and write
    for (int k = 0; k < 8; k++) begin
      run_req(32'hFF00_0FFF + 32'(k) * 32'h0004_1000, 2, k[0], k, 32'h0004_0010);
      run_req(32'h8000_1FFE + 32'(k) * 32'h0300_0000, 4099, !k[0], 7 - k, 32'h0001_2345);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule